// File: doc/BRIEF.md
# I2C Slave Bus Condition Monitor

This block sits on the target side of a two-wire serial bus. It watches the clock and data lines and sorts every data-line edge made while the clock is high into a START (data falling) or a STOP (data rising). A data-line edge made while the clock is low is ordinary bit traffic and is ignored. A phase register records where the surrounding data path thinks the transfer is. A table of acceptance rules decides, for each phase, whether a START or STOP is legal, whether it closes the frame, or whether it is a bus fault. A fault phase is sticky and only a STOP leaves it.

The data path moves the phase through a load strobe with a phase code, and counts bits with a shift strobe that decrements a bit counter. Every START that opens or reopens a frame loads the counter and arms a transaction timer. A STOP that closes the frame cancels the timer. If the timer runs out, the block reports it and falls back to idle. When a START or STOP lands exactly on the first bit of a byte in an addressing or receive phase, the block requests a one-cycle clock stretch while it reports the event. Address matching and data buffering belong to other blocks.

Top module: `i2c_cond_monitor`

## Requirements
- R1: After reset the phase output is 0 (idle), the bit count is 0, and all event outputs and the stretch request are low.
- R2: A data-line edge while the clock line is high is a bus condition: falling is START, rising is STOP. A data-line edge while the clock line is low changes no phase, count or output in any phase.
- R3: In idle (code 0) a START pulses start_pulse once, sets the phase to 1 (frame opened), loads the bit count with BITS (8) and arms the timer. A STOP in idle is ignored.
- R4: In phases 1, 2, 4, 7, 8, 9, 10, 11 and 12, any START or STOP pulses berr_pulse once and sets the phase to 6 (fault).
- R5: In phases 5 (awaiting end) and 6 (fault), a STOP pulses stop_pulse, raises scl_hold for one cycle, disarms the timer and returns the phase to 0.
- R6: In phase 5 a START pulses rstart_pulse, reloads the bit count with 8, re-arms the timer and sets phase 2 (reopened). In phase 6 a START is ignored.
- R7: In phases 3 (write addressing) and 13 (receive), a START or STOP with a bit count other than 7 pulses berr_pulse and sets phase 6.
- R8: In phases 3 and 13 with the bit count equal to 7, any condition raises scl_hold for one cycle. A STOP then pulses stop_pulse and returns to phase 0. A START pulses rstart_pulse, reloads the count with 8 and sets phase 2.
- R9: TMO_CYCLES clocks after the timer is armed, if no STOP has cancelled it, tmo_pulse pulses once and the phase returns to 0.
- R10: A phase_wr strobe loads phase_code into the phase when the code is 0 to 13. Codes 14 and 15 leave the phase unchanged.
- R11: Each bit_shift strobe lowers the bit count by one. At 0 the count stays at 0.
- R12: scl_hold lasts exactly one cycle per event, and at most one of the five event pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line level |
| sda_i | input | 1 | Raw serial data line level |
| phase_wr | input | 1 | Strobe: load phase_code into the phase |
| phase_code | input | 4 | Phase code to load (0 to 13 valid) |
| bit_shift | input | 1 | Strobe: one bit moved, decrement bit count |
| start_pulse | output | 1 | START opened a frame from idle |
| rstart_pulse | output | 1 | Repeated START reopened a frame |
| stop_pulse | output | 1 | STOP closed the frame |
| berr_pulse | output | 1 | Bus condition in an illegal place |
| tmo_pulse | output | 1 | Transaction timer expired |
| scl_hold | output | 1 | One-cycle request to hold the clock line low |
| phase_o | output | 4 | Current phase code |
| bit_count | output | $clog2(BITS+1) | Bits left in the current byte |

## Verification
Directed sequences place the block in each phase class and apply a START, a STOP and low-clock data toggles. This separates the strict, closing, boundary and idle acceptance rules. Boundary runs set the count to exactly 7 and then to 8 in the same phase, which tells the stretch-and-close path apart from the fault path. A seeded random mix of phase loads, shifts, data toggles and conditions is compared after every step against a bench model of the rule table. Separate runs cover timer expiry, out-of-range phase codes and counter saturation.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    PH_IDLE       = 4'd0,
    PH_BEGIN      = 4'd1,
    PH_RESTART    = 4'd2,
    PH_ADDR_WR    = 4'd3,
    PH_ADDR_RD    = 4'd4,
    PH_HOLD_END   = 4'd5,
    PH_FAULT      = 4'd6,
    PH_ACK_TX     = 4'd7,
    PH_ACK_WAIT   = 4'd8,
    PH_ACK_RX     = 4'd9,
    PH_RDACK      = 4'd10,
    PH_RDACK_WAIT = 4'd11,
    PH_TX         = 4'd12,
    PH_RX         = 4'd13
  } phase_e;

  // How a phase treats a START or STOP on the bus
  typedef enum logic [1:0] {
    RULE_OPEN,      // idle: START opens, STOP ignored
    RULE_STRICT,    // any condition is a fault
    RULE_BOUNDARY,  // legal only on the first bit of a byte
    RULE_CLOSING    // STOP closes; START reopens unless faulted
  } rule_e;

  typedef struct packed {
    logic start;
    logic rstart;
    logic stop;
    logic berr;
    logic tmo;
    logic hold;
  } evt_t;

  localparam logic [3:0] LAST_CODE = 4'd13;

  function automatic rule_e rule_of(phase_e p);
    case (p)
      PH_IDLE:               return RULE_OPEN;
      PH_ADDR_WR, PH_RX:     return RULE_BOUNDARY;
      PH_HOLD_END, PH_FAULT: return RULE_CLOSING;
      default:               return RULE_STRICT;
    endcase
  endfunction

  function automatic logic code_ok(logic [3:0] c);
    return c <= LAST_CODE;
  endfunction

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= RESET_VAL;
        else        chain[0] <= pin;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RESET_VAL;
        else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= RESET_VAL;
    else        prev <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;

  a_r2_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
endmodule

// File: rtl/i2cm_timer.sv
module i2cm_timer #(
  parameter int TMO_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clear,
  output logic armed,
  output logic expire
);
  localparam int W = $clog2(TMO_CYCLES + 1);
  localparam logic [W-1:0] LOAD = W'(TMO_CYCLES);

  logic [W-1:0] left;

  assign expire = armed && (left == W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      left  <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      left  <= LOAD;
    end else if (clear || expire) begin
      armed <= 1'b0;
    end else if (armed) begin
      left <= left - W'(1);
    end

  a_r9_left_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (left != '0 && left <= LOAD));
  a_r9_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed) && !$past(arm)) |-> left == $past(left) - W'(1));
endmodule

// File: rtl/i2c_cond_monitor.sv
module i2c_cond_monitor
  import i2cm_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_CYCLES  = 2000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic                      phase_wr,
  input  logic [3:0]                phase_code,
  input  logic                      bit_shift,
  output logic                      start_pulse,
  output logic                      rstart_pulse,
  output logic                      stop_pulse,
  output logic                      berr_pulse,
  output logic                      tmo_pulse,
  output logic                      scl_hold,
  output logic [3:0]                phase_o,
  output logic [$clog2(BITS+1)-1:0] bit_count
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] FULL  = CW'(BITS);
  localparam logic [CW-1:0] FIRST = CW'(BITS - 1);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_c, stop_c;
  logic tmr_armed, tmr_expire, do_arm, do_clear;
  phase_e state, nx_state;
  logic [CW-1:0] nx_cnt;
  evt_t ev, ev_q;
  logic acted;

  i2cm_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl (
    .clk(clk), .rst_n(rst_n), .pin(scl_i),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  i2cm_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_n), .pin(sda_i),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  // A data edge is judged against the clock level of the same cycle
  assign start_c = sda_fall & scl_lvl;
  assign stop_c  = sda_rise & scl_lvl;

  i2cm_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .arm(do_arm), .clear(do_clear),
    .armed(tmr_armed), .expire(tmr_expire));

  always_comb begin
    nx_state = state;
    nx_cnt   = bit_count;
    ev       = '0;
    do_arm   = 1'b0;
    do_clear = 1'b0;
    if (start_c || stop_c) begin
      unique case (rule_of(state))
        RULE_OPEN: if (start_c) begin
          nx_state = PH_BEGIN; nx_cnt = FULL; do_arm = 1'b1; ev.start = 1'b1;
        end
        RULE_STRICT: begin
          nx_state = PH_FAULT; ev.berr = 1'b1;
        end
        RULE_CLOSING: if (stop_c) begin
          nx_state = PH_IDLE; do_clear = 1'b1; ev.stop = 1'b1; ev.hold = 1'b1;
        end else if (state == PH_HOLD_END) begin
          nx_state = PH_RESTART; nx_cnt = FULL; do_arm = 1'b1; ev.rstart = 1'b1;
        end
        RULE_BOUNDARY: if (bit_count != FIRST) begin
          nx_state = PH_FAULT; ev.berr = 1'b1;
        end else begin
          ev.hold = 1'b1;
          if (stop_c) begin
            nx_state = PH_IDLE; do_clear = 1'b1; ev.stop = 1'b1;
          end else begin
            nx_state = PH_RESTART; nx_cnt = FULL; do_arm = 1'b1; ev.rstart = 1'b1;
          end
        end
      endcase
    end
    acted = |ev;
    if (!acted) begin
      if (tmr_expire) begin
        nx_state = PH_IDLE; ev.tmo = 1'b1;
      end else if (phase_wr && code_ok(phase_code)) begin
        nx_state = phase_e'(phase_code);
      end
      if (bit_shift && nx_cnt != '0) nx_cnt = nx_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= PH_IDLE;
      bit_count <= '0;
      ev_q      <= '0;
    end else begin
      state     <= nx_state;
      bit_count <= nx_cnt;
      ev_q      <= ev;
    end

  assign start_pulse  = ev_q.start;
  assign rstart_pulse = ev_q.rstart;
  assign stop_pulse   = ev_q.stop;
  assign berr_pulse   = ev_q.berr;
  assign tmo_pulse    = ev_q.tmo;
  assign scl_hold     = ev_q.hold;
  assign phase_o      = state;

  a_r3_start_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(state) == PH_IDLE && bit_count == FULL && tmr_armed));
  a_r4_error_lands_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    berr_pulse |-> state == PH_FAULT);
  a_r5_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> (state == PH_IDLE && !tmr_armed));
  a_r6_restart_arms: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_pulse |-> (state == PH_RESTART && tmr_armed && bit_count == FULL));
  a_r8_hold_with_close: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> (stop_pulse || rstart_pulse));
  a_r9_timeout_idles: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> (state == PH_IDLE && !tmr_armed && $past(tmr_armed)));
  a_r10_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o <= LAST_CODE);
  a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= FULL);
  a_r12_hold_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |=> !scl_hold);
  a_r12_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, rstart_pulse, stop_pulse, berr_pulse, tmo_pulse}));
  a_r2_clock_edges_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_rise || scl_fall) && !sda_rise && !sda_fall) |=> !(berr_pulse || start_pulse || rstart_pulse || stop_pulse));
endmodule

// File: tb/test_i2c_cond_monitor.sv
module test_i2c_cond_monitor;
  localparam int BITS = 8;
  localparam int TMO  = 2000;
  localparam int CW   = $clog2(BITS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic phase_wr = 1'b0, bit_shift = 1'b0;
  logic [3:0] phase_code = 4'd0;
  logic start_pulse, rstart_pulse, stop_pulse, berr_pulse, tmo_pulse, scl_hold;
  logic [3:0] phase_o;
  logic [CW-1:0] bit_count;

  int n_cmp = 0, n_bad = 0;
  int c_start = 0, c_rstart = 0, c_stop = 0, c_berr = 0, c_tmo = 0, c_hold = 0;
  int m_st = 0, m_cnt = 0;
  int e_start = 0, e_rstart = 0, e_stop = 0, e_berr = 0, e_tmo = 0, e_hold = 0;

  always #2 clk = ~clk;

  i2c_cond_monitor #(.BITS(BITS), .SYNC_STAGES(2), .TMO_CYCLES(TMO)) i_i2c_cond_monitor (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .phase_wr(phase_wr), .phase_code(phase_code), .bit_shift(bit_shift),
    .start_pulse(start_pulse), .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
    .berr_pulse(berr_pulse), .tmo_pulse(tmo_pulse), .scl_hold(scl_hold),
    .phase_o(phase_o), .bit_count(bit_count));

  always @(negedge clk) if (rst_n) begin
    if (start_pulse)  c_start++;
    if (rstart_pulse) c_rstart++;
    if (stop_pulse)   c_stop++;
    if (berr_pulse)   c_berr++;
    if (tmo_pulse)    c_tmo++;
    if (scl_hold)     c_hold++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    chk(req, "phase", int'(phase_o), m_st);
    chk(req, "count", int'(bit_count), m_cnt);
    chk(req, "starts", c_start, e_start);
    chk(req, "rstarts", c_rstart, e_rstart);
    chk(req, "stops", c_stop, e_stop);
    chk(req, "berrs", c_berr, e_berr);
    chk(req, "tmos", c_tmo, e_tmo);
    chk(req, "R12 hold cycles", c_hold, e_hold);
  endtask

  // Rule table restated from the requirements
  function automatic int rule(input int st);
    if (st == 0) return 0;                    // open
    if (st == 3 || st == 13) return 2;        // boundary
    if (st == 5 || st == 6) return 3;         // closing
    return 1;                                 // strict
  endfunction

  task automatic model_cond(input bit is_start);
    case (rule(m_st))
      0: if (is_start) begin m_st = 1; m_cnt = BITS; e_start++; end
      1: begin m_st = 6; e_berr++; end
      3: if (!is_start) begin m_st = 0; e_stop++; e_hold++; end
         else if (m_st == 5) begin m_st = 2; m_cnt = BITS; e_rstart++; end
      default: if (m_cnt != BITS - 1) begin m_st = 6; e_berr++; end
         else begin
           e_hold++;
           if (is_start) begin m_st = 2; m_cnt = BITS; e_rstart++; end
           else begin m_st = 0; e_stop++; end
         end
    endcase
  endtask

  task automatic bus_cond(input bit is_start);
    scl_i = 1'b0; repeat (4) @(negedge clk);
    sda_i = is_start ? 1'b1 : 1'b0; repeat (4) @(negedge clk);
    scl_i = 1'b1; repeat (4) @(negedge clk);
    sda_i = ~sda_i; repeat (8) @(negedge clk);
  endtask

  task automatic op_cond(input bit is_start, input string req);
    bus_cond(is_start);
    model_cond(is_start);
    check_all(req);
  endtask

  task automatic op_data(input string req);
    scl_i = 1'b0; repeat (4) @(negedge clk);
    sda_i = ~sda_i; repeat (4) @(negedge clk);
    sda_i = ~sda_i; repeat (4) @(negedge clk);
    sda_i = ~sda_i; repeat (8) @(negedge clk);
    check_all(req);
  endtask

  task automatic op_phase(input int code, input string req);
    @(negedge clk); phase_wr = 1'b1; phase_code = 4'(code);
    @(negedge clk); phase_wr = 1'b0;
    if (code <= 13) m_st = code;
    check_all(req);
  endtask

  task automatic op_shift(input string req);
    @(negedge clk); bit_shift = 1'b1;
    @(negedge clk); bit_shift = 1'b0;
    if (m_cnt > 0) m_cnt--;
    check_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; scl_i = 1'b1; sda_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_st = 0; m_cnt = 0;
    e_start = c_start; e_rstart = c_rstart; e_stop = c_stop;
    e_berr = c_berr; e_tmo = c_tmo; e_hold = c_hold;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    do_reset();
    // R1 reset state
    chk("R1", "phase", int'(phase_o), 0);
    chk("R1", "count", int'(bit_count), 0);
    chk("R1", "pulses", int'({start_pulse, rstart_pulse, stop_pulse, berr_pulse, tmo_pulse, scl_hold}), 0);

    op_data("R2 idle data");
    op_cond(1'b0, "R3 stop in idle ignored");
    chk("R3", "idle after stop", int'(phase_o), 0);
    op_cond(1'b1, "R3 start");
    chk("R3", "phase after start", int'(phase_o), 1);
    chk("R3", "count after start", int'(bit_count), 8);
    op_data("R2 data in open frame");

    op_phase(3, "R10 load write addressing");
    op_cond(1'b0, "R7 stop at count 8");
    chk("R7", "fault", int'(phase_o), 6);
    op_cond(1'b1, "R6 start in fault ignored");
    chk("R6", "still fault", int'(phase_o), 6);
    op_cond(1'b0, "R5 stop leaves fault");
    chk("R5", "idle", int'(phase_o), 0);

    op_cond(1'b1, "R3 start");
    op_phase(3, "R10");
    op_shift("R11 to 7");
    op_cond(1'b0, "R8 stop at boundary");
    chk("R8", "idle after boundary stop", int'(phase_o), 0);

    op_cond(1'b1, "R3 start");
    op_phase(13, "R10");
    op_shift("R11 to 7");
    op_cond(1'b1, "R8 start at boundary");
    chk("R8", "reopened", int'(phase_o), 2);
    chk("R8", "reload", int'(bit_count), 8);
    op_cond(1'b1, "R4 start while reopened");
    op_cond(1'b0, "R5 cleanup");

    op_cond(1'b1, "R3 start");
    op_phase(5, "R10 awaiting end");
    op_cond(1'b1, "R6 start in awaiting end");
    chk("R6", "reopened", int'(phase_o), 2);
    op_phase(5, "R10");
    op_cond(1'b0, "R5 stop in awaiting end");

    op_phase(14, "R10 code 14 ignored");
    op_phase(15, "R10 code 15 ignored");
    chk("R10", "phase after bad codes", int'(phase_o), 0);
    op_phase(12, "R10 load transmit");
    op_cond(1'b0, "R4 stop while transmitting");
    op_phase(9, "R10");
    op_cond(1'b1, "R4 start in ack receive");
    op_cond(1'b0, "R5 cleanup");

    op_cond(1'b1, "R3 start");
    for (int k = 0; k < 10; k++) op_shift("R11 saturation");
    chk("R11", "floor", int'(bit_count), 0);
    op_cond(1'b0, "R4 stop while opened");
    op_cond(1'b0, "R5 cleanup");

    // R9 timeout
    op_cond(1'b1, "R9 arm");
    repeat (TMO - 200) @(negedge clk);
    chk("R9", "no early timeout", c_tmo, e_tmo);
    repeat (400) @(negedge clk);
    e_tmo++; m_st = 0;
    check_all("R9 expired");
    // R9 restart re-arms: expiry then counts from the reopening
    op_cond(1'b1, "R9 arm again");
    op_phase(5, "R10");
    repeat (TMO - 300) @(negedge clk);
    op_cond(1'b1, "R9 rearm by restart");
    repeat (200) @(negedge clk);
    chk("R9", "rearm delays expiry", c_tmo, e_tmo);
    repeat (TMO) @(negedge clk);
    e_tmo++; m_st = 0;
    check_all("R9 expired after rearm");

    // Seeded random mix against the model
    do_reset();
    for (int k = 0; k < 50; k++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 3)      op_cond(pick[0], "R4 R7 random condition");
      else if (pick < 5) op_phase(int'($urandom_range(0, 15)), "R10 random load");
      else if (pick < 8) op_shift("R11 random shift");
      else               op_data("R2 random data");
    end
    summary();
  end
endmodule